// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a bank of thirty-two 8-bit control registers. Each transaction is one 16-bit frame, sent most significant bit first. The master's first byte holds a direction flag, a 5-bit register address, an even-parity bit and one spare bit. The master's second byte holds the value to store when the direction is write. On the same frame the slave returns two bytes. The first is always the status register at address 0x0C. The second is the contents of the addressed register.

The SPI pins are brought into a faster system clock through two-flop synchronizers, and edges are detected there. The system clock must run at least eight times faster than SCK. The frame engine counts sampling edges, checks parity and takes a snapshot of the addressed register while the parity bit is being transferred. A write is stored only when chip-select is released, and only if the frame was well formed. Frames that are too short or too long, and writes with bad parity, are discarded and reported on sticky error flags.

Top module: `spi_regbank_slave`

## Requirements
- R1: While `rst` is high and afterwards until written, all 32 registers read as 0x00. Both error flags are low and `miso_oe_o` is low.
- R2: The slave samples MOSI on falling SCK edges and updates MISO only after rising SCK edges. Both directions send the most significant bit first.
- R3: `miso_oe_o` is high while chip-select is low (frame active). It is low, requesting high impedance, while chip-select is high.
- R4: The first slave byte (frame bits 15..8) is the value of register 0x0C at frame start, whatever the direction or address.
- R5: A write (frame bit 15 = 0) stores frame bits 7..0 into the register at address bits 14..10. The store takes effect only after chip-select rises, and only when the frame is valid with correct parity.
- R6: A frame is valid only if exactly 16 falling SCK edges occur while chip-select is low. Any other count, including zero, discards the frame and sets `frame_err_o`.
- R7: Bit 9 must make the count of ones over bits 15..9 even. A write that breaks this rule is discarded and sets `parity_err_o`.
- R8: Both error flags stay set until `err_clr_i` is pulsed. If a new error and a clear fall in the same cycle, the error wins.
- R9: On a read (bit 15 = 1), the master's data byte and the parity bit are ignored. No register changes and no parity error is raised.
- R10: The second slave byte is the addressed register's value captured at the seventh sampling edge, when the parity bit is taken. For a write, this is the value from before the write.
- R11: Frame bit 8 is a spare bit. Its value has no effect on any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst | input | 1 | Synchronous active-high reset |
| ss_n_i | input | 1 | Chip-select from master, active low |
| sck_i | input | 1 | Serial clock from master, idle low |
| mosi_i | input | 1 | Serial data from master |
| err_clr_i | input | 1 | Clears both sticky error flags |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Enable for the MISO pad's tri-state driver |
| parity_err_o | output | 1 | Sticky flag: write discarded for bad parity |
| frame_err_o | output | 1 | Sticky flag: frame discarded for wrong edge count |

## Verification
Several properties are checked on every cycle. MISO holds steady except after a rising SCK edge. The driver enable follows the synchronized chip-select. A register store happens only in the cycle after chip-select rises. Each error flag rises only two cycles after a frame end and then stays set until cleared. Other behaviour can only be shown by the bench's frames, run against a reference model of the register bank. That includes the returned status and data bytes, the pre-write value on writes, the handling of parity and of the spare bit, and the discarding of frames with the wrong edge count.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    parameter int FRAME_BITS  = 16;
    parameter int ADDR_W      = 5;
    parameter int DATA_W      = 8;
    parameter int NUM_REGS    = 1 << ADDR_W;
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h0C;

    // First master byte: direction, address, parity, spare
    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic              par;
        logic              spare;
    } hdr_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef enum logic [1:0] {
        END_NONE   = 2'd0,
        END_OK     = 2'd1,
        END_PARITY = 2'd2,
        END_LENGTH = 2'd3
    } end_kind_t;

    // Even parity over direction, address and parity bit
    function automatic logic hdr_parity_ok(hdr_t h);
        return ~(^{h.rd, h.addr, h.par});
    endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] chain [STAGES];
    logic [N-1:0] prev;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
    import spi_rb_pkg::*;
#(
    parameter int                AW      = ADDR_W,
    parameter int                DW      = DATA_W,
    parameter logic [ADDR_W-1:0] STAT_AD = STATUS_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic [DW-1:0] status_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (wr_i.en && (wr_i.addr == AW'(i)))
                mem[i] <= wr_i.data;
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign status_o  = mem[STAT_AD];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
    import spi_rb_pkg::*;
#(
    parameter int FB = FRAME_BITS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ss_lvl_i,
    input  logic          ss_fall_i,
    input  logic          ss_rise_i,
    input  logic          sck_rise_i,
    input  logic          sck_fall_i,
    input  logic          mosi_i,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output wr_req_t       wr_o,
    output end_kind_t     end_o,
    output logic          miso_o,
    output logic          miso_oe_o
);
    localparam int CNT_W   = $clog2(FB + 2);
    localparam int IDX_W   = $clog2(FB);
    localparam int CNT_MAX = FB + 1;
    localparam int SNAP_AT = AW + 1;   // edges already seen when parity is sampled

    logic [FB-1:0]    rx_sr;
    logic [FB-1:0]    tx_word;
    logic [CNT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] rise_cnt;
    logic [IDX_W-1:0] tx_idx;
    logic             miso_q;
    hdr_t             hdr_w;

    assign hdr_w     = hdr_t'(rx_sr[FB-1 -: $bits(hdr_t)]);
    assign rd_addr_o = rx_sr[AW-1:0];
    assign tx_idx    = IDX_W'(CNT_W'(FB - 1) - rise_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr    <= '0;
            tx_word  <= '0;
            fall_cnt <= '0;
            rise_cnt <= '0;
            miso_q   <= 1'b0;
            wr_o     <= '0;
            end_o    <= END_NONE;
        end else begin
            wr_o.en <= 1'b0;
            end_o   <= END_NONE;
            if (ss_fall_i) begin
                rx_sr    <= '0;
                fall_cnt <= '0;
                rise_cnt <= '0;
                miso_q   <= 1'b0;
                tx_word  <= {status_i, {DW{1'b0}}};
            end else if (ss_rise_i) begin
                if (fall_cnt == CNT_W'(FB)) begin
                    if (hdr_w.rd) begin
                        end_o <= END_OK;
                    end else if (hdr_parity_ok(hdr_w)) begin
                        wr_o.en   <= 1'b1;
                        wr_o.addr <= hdr_w.addr;
                        wr_o.data <= rx_sr[DW-1:0];
                        end_o     <= END_OK;
                    end else begin
                        end_o <= END_PARITY;
                    end
                end else begin
                    end_o <= END_LENGTH;
                end
            end else if (!ss_lvl_i) begin
                if (sck_fall_i) begin
                    rx_sr <= {rx_sr[FB-2:0], mosi_i};
                    if (fall_cnt != CNT_W'(CNT_MAX))
                        fall_cnt <= fall_cnt + 1'b1;
                    if (fall_cnt == CNT_W'(SNAP_AT))
                        tx_word[DW-1:0] <= rd_data_i;
                end
                if (sck_rise_i && (rise_cnt < CNT_W'(FB))) begin
                    miso_q   <= tx_word[tx_idx];
                    rise_cnt <= rise_cnt + 1'b1;
                end
            end
        end
    end

    assign miso_o    = miso_q;
    assign miso_oe_o = ~ss_lvl_i;
endmodule

// File: rtl/spi_rb_errflags.sv
module spi_rb_errflags
    import spi_rb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  end_kind_t end_i,
    input  logic      clr_i,
    output logic      par_err_o,
    output logic      frm_err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            par_err_o <= 1'b0;
            frm_err_o <= 1'b0;
        end else begin
            par_err_o <= (end_i == END_PARITY) | (par_err_o & ~clr_i);
            frm_err_o <= (end_i == END_LENGTH) | (frm_err_o & ~clr_i);
        end
    end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ss_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic err_clr_i,
    output logic miso_o,
    output logic miso_oe_o,
    output logic parity_err_o,
    output logic frame_err_o
);
    localparam int PIN_SS   = 2;
    localparam int PIN_SCK  = 1;
    localparam int PIN_MOSI = 0;

    logic [2:0]        pin_lvl, pin_rise, pin_fall;
    logic              ss_lvl, ss_rise, ss_fall, sck_rise, sck_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data, status_byte;
    wr_req_t           wr_req;
    end_kind_t         end_kind;

    spi_rb_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ss_n_i, sck_i, mosi_i}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign ss_lvl   = pin_lvl[PIN_SS];
    assign ss_rise  = pin_rise[PIN_SS];
    assign ss_fall  = pin_fall[PIN_SS];
    assign sck_rise = pin_rise[PIN_SCK];
    assign sck_fall = pin_fall[PIN_SCK];

    spi_rb_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .ss_lvl_i   (ss_lvl),
        .ss_fall_i  (ss_fall),
        .ss_rise_i  (ss_rise),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .mosi_i     (pin_lvl[PIN_MOSI]),
        .status_i   (status_byte),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_o       (wr_req),
        .end_o      (end_kind),
        .miso_o     (miso_o),
        .miso_oe_o  (miso_oe_o)
    );

    spi_rb_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_req),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .status_o  (status_byte)
    );

    spi_rb_errflags u_err (
        .clk       (clk),
        .rst       (rst),
        .end_i     (end_kind),
        .clr_i     (err_clr_i),
        .par_err_o (parity_err_o),
        .frm_err_o (frame_err_o)
    );
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker (
    input logic clk,
    input logic rst,
    input logic ss_n_i,
    input logic err_clr_i,
    input logic miso_o,
    input logic miso_oe_o,
    input logic parity_err_o,
    input logic frame_err_o,
    input logic ss_rise,
    input logic ss_fall,
    input logic sck_rise,
    input logic wr_en
);
    // R2: MISO moves only right after a rising SCK edge (or frame start)
    assert_miso_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(sck_rise) && !$past(ss_fall)) |-> $stable(miso_o));

    // R3: chip-select high two cycles ago releases the driver
    assert_release_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        $past(ss_n_i, 2) |-> !miso_oe_o);

    // R5: a register store follows chip-select rising
    assert_write_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(ss_rise));

    // R6: length error appears only after a frame end
    assert_frame_flag_origin_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err_o) |-> $past(ss_rise, 2));

    // R7: parity error appears only after a frame end
    assert_parity_flag_origin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(parity_err_o) |-> $past(ss_rise, 2));

    // R8: flags hold until cleared
    assert_parity_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (parity_err_o && !err_clr_i) |=> parity_err_o);

    assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_err_o && !err_clr_i) |=> frame_err_o);
endmodule

bind spi_regbank_slave spi_rb_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ss_n_i       (ss_n_i),
    .err_clr_i    (err_clr_i),
    .miso_o       (miso_o),
    .miso_oe_o    (miso_oe_o),
    .parity_err_o (parity_err_o),
    .frame_err_o  (frame_err_o),
    .ss_rise      (ss_rise),
    .ss_fall      (ss_fall),
    .sck_rise     (sck_rise),
    .wr_en        (wr_req.en)
);

// File: tb/spi_regbank_slave_test.sv
`timescale 1ns/1ps
module spi_regbank_slave_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0, err_clr = 1'b0;
    logic miso, miso_oe, par_err, frm_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] model [32];
    logic       exp_par = 1'b0;
    logic       exp_frm = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spi_regbank_slave uut (
        .clk          (clk),
        .rst          (rst),
        .ss_n_i       (ss_n),
        .sck_i        (sck),
        .mosi_i       (mosi),
        .err_clr_i    (err_clr),
        .miso_o       (miso),
        .miso_oe_o    (miso_oe),
        .parity_err_o (par_err),
        .frame_err_o  (frm_err)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic rd, input logic [4:0] addr,
                                       input logic [7:0] data, input logic xbit,
                                       input logic badpar);
        return {rd, addr, (^{rd, addr}) ^ badpar, xbit, data};
    endfunction

    task automatic xfer(input logic [15:0] tx, input int nfall, output logic [15:0] rx);
        rx   = '0;
        ss_n = 1'b0;
        wait_clk(8);
        chk("R3 driver enabled in frame", {15'd0, miso_oe}, 16'd1);
        for (int i = 0; i < nfall; i++) begin
            sck  = 1'b1;
            mosi = (i < 16) ? tx[15-i] : 1'b0;
            wait_clk(8);
            if (i < 16) rx[15-i] = miso;
            sck = 1'b0;
            wait_clk(8);
        end
        wait_clk(4);
        ss_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic run_frame(input logic [15:0] tx, input int nfall, input string tag);
        logic [15:0] rx;
        logic [7:0]  exp_stat, exp_dat;
        logic [4:0]  a;
        a        = tx[14:10];
        exp_stat = model[12];
        exp_dat  = model[a];
        xfer(tx, nfall, rx);
        if (nfall == 16) begin
            chk("R4 status byte", {8'd0, rx[15:8]}, {8'd0, exp_stat});
            chk(tag, {8'd0, rx[7:0]}, {8'd0, exp_dat});
            if (!tx[15]) begin
                if (~^tx[15:9]) model[a] = tx[7:0];
                else            exp_par  = 1'b1;
            end
        end else begin
            exp_frm = 1'b1;
        end
        chk("R7 parity flag", {15'd0, par_err}, {15'd0, exp_par});
        chk("R6 frame flag", {15'd0, frm_err}, {15'd0, exp_frm});
        chk("R3 driver released", {15'd0, miso_oe}, 16'd0);
    endtask

    task automatic clear_flags();
        err_clr = 1'b1;
        wait_clk(1);
        err_clr = 1'b0;
        wait_clk(1);
        exp_par = 1'b0;
        exp_frm = 1'b0;
        chk("R8 parity cleared", {15'd0, par_err}, 16'd0);
        chk("R8 frame cleared", {15'd0, frm_err}, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1 reset state
        chk("R1 parity flag at reset", {15'd0, par_err}, 16'd0);
        chk("R1 frame flag at reset", {15'd0, frm_err}, 16'd0);
        chk("R1 driver off at reset", {15'd0, miso_oe}, 16'd0);
        for (int i = 0; i < 32; i += 7)
            run_frame(mk(1'b1, 5'(i), 8'h00, 1'b0, 1'b0), 16, "R1 register reset value");

        // R4 status byte follows register 0x0C
        run_frame(mk(1'b0, 5'h0C, 8'hA5, 1'b0, 1'b0), 16, "R10 pre-write status");
        run_frame(mk(1'b1, 5'h03, 8'h00, 1'b0, 1'b0), 16, "R2 R4 read after status write");

        // R5 / R10 write then read back
        run_frame(mk(1'b0, 5'h05, 8'h3C, 1'b0, 1'b0), 16, "R10 old value on write");
        run_frame(mk(1'b1, 5'h05, 8'h00, 1'b0, 1'b0), 16, "R5 stored value read back");
        run_frame(mk(1'b0, 5'h05, 8'hC3, 1'b0, 1'b0), 16, "R10 pre-write value");

        // R7 bad parity write discarded
        run_frame(mk(1'b0, 5'h05, 8'h11, 1'b0, 1'b1), 16, "R7 data byte on bad write");
        run_frame(mk(1'b1, 5'h05, 8'h00, 1'b0, 1'b0), 16, "R7 register unchanged");
        clear_flags();

        // R6 wrong lengths
        run_frame(mk(1'b0, 5'h07, 8'h77, 1'b0, 1'b0), 12, "R6 short");
        run_frame(mk(1'b1, 5'h07, 8'h00, 1'b0, 1'b0), 16, "R6 no store after short");
        clear_flags();
        run_frame(mk(1'b0, 5'h07, 8'h77, 1'b0, 1'b0), 17, "R6 long");
        run_frame(mk(1'b0, 5'h07, 8'h66, 1'b0, 1'b0), 0, "R6 empty");
        run_frame(mk(1'b1, 5'h07, 8'h00, 1'b0, 1'b0), 16, "R6 no store after long");
        clear_flags();

        // R9 read ignores parity and data byte
        run_frame(mk(1'b1, 5'h05, 8'hFF, 1'b0, 1'b1), 16, "R9 read with bad parity");
        run_frame(mk(1'b1, 5'h05, 8'h00, 1'b0, 1'b0), 16, "R9 register untouched");

        // R11 spare bit has no effect
        run_frame(mk(1'b0, 5'h1F, 8'h5E, 1'b1, 1'b0), 16, "R11 write with spare set");
        run_frame(mk(1'b1, 5'h1F, 8'h00, 1'b1, 1'b0), 16, "R11 read back with spare set");

        // Random traffic
        for (int n = 0; n < 150; n++) begin
            logic       rd, bp, xb;
            logic [4:0] ad;
            logic [7:0] dt;
            int         nf;
            rd = 1'($urandom % 2);
            ad = 5'($urandom);
            dt = 8'($urandom);
            xb = 1'($urandom);
            bp = ($urandom % 6) == 0;
            nf = 16;
            if (($urandom % 10) == 0) begin
                nf = $urandom % 21;
                if (nf == 16) nf = 15;
            end
            run_frame(mk(rd, ad, dt, xb, bp), nf, "R2 R10 random data byte");
            if (exp_par || exp_frm) clear_flags();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule